// File: doc/BRIEF.md
# Function-Code ALU with Signed Less-Than Flag

This block is a purely combinational arithmetic logic unit of parameterised width (32 bits by default). A 3-bit function code selects one of seven operations on two operands. The upper code bit does two jobs at once. It complements the second operand for every path, and it feeds the carry input of the single shared adder, so that the adder subtracts. The lower two code bits pick which result reaches the output: the bitwise AND, the bitwise OR, the adder sum, or the sign bit of the adder result.

The less-than result is the top bit of the difference A − B, widened with zeros. It is correct whenever the subtraction does not overflow. No overflow correction is applied. A zero indication accompanies every result. One code (011) has no operation assigned, and it drives a defined all-zero result.

A parameter chooses how the adder is built: a plain arithmetic sum, or an explicit ripple chain generated bit by bit. Both forms give the same result.

Top module: `fcode_alu`

## Requirements
- R1: Function code 3'b000 drives the output with the bitwise AND of the two operands.
- R2: Function code 3'b001 drives the output with the bitwise OR of the two operands.
- R3: Function code 3'b010 drives the output with the operand sum, truncated to the operand width.
- R4: Function code 3'b011 drives an all-zero output.
- R5: Function code 3'b100 gives A AND (NOT B), and function code 3'b101 gives A OR (NOT B).
- R6: Function code 3'b110 gives A − B in two's complement, truncated to the operand width.
- R7: Function code 3'b111 places the most significant bit of A − B in output bit 0 and sets every other output bit to 0. For a 32-bit block, A = 25 and B = 32 give 0x00000001.
- R8: The zero output is 1 exactly when every bit of the result is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_in | input | WIDTH | First operand |
| b_in | input | WIDTH | Second operand (complemented when code bit 2 is set) |
| func | input | 3 | Function code |
| y_out | output | WIDTH | Result |
| zero_out | output | 1 | High when the result is all zeros |

## Verification
The bench sweeps every operand pair and every function code on a 4-bit instance built with the ripple adder. It also runs a set of chosen cases on a 32-bit instance. The sweep catches three kinds of fault:
- A missing carry-in on subtraction, which leaves the 110 and 111 results one below the correct value.
- Complementing B only for the arithmetic paths, which breaks codes 100 and 101.
- A less-than path that takes the wrong bit or fails to clear the upper bits.

The unused code is checked on every operand pair, so a result that passes any operand through is reported. Both results either side of the difference's sign flip are also exercised: 25 against 32, equal operands, and pairs where the subtraction wraps.

// File: rtl/fcode_alu_pkg.sv
package fcode_alu_pkg;
   typedef enum logic [1:0] {
      PICK_AND  = 2'b00,
      PICK_OR   = 2'b01,
      PICK_SUM  = 2'b10,
      PICK_SIGN = 2'b11
   } pick_e;

   localparam int ADDER_ARITH  = 0;
   localparam int ADDER_RIPPLE = 1;
endpackage

// File: rtl/fcode_alu_operand.sv
module fcode_alu_operand #(
   parameter int WIDTH = 32
) (
   input  logic [WIDTH-1:0] b_raw,
   input  logic             invert,
   output logic [WIDTH-1:0] b_eff
);
   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      assign b_eff[i] = b_raw[i] ^ invert;
   end
endmodule

// File: rtl/fcode_alu_adder.sv
module fcode_alu_adder
   import fcode_alu_pkg::*;
#(
   parameter int WIDTH = 32,
   parameter int KIND  = ADDER_ARITH
) (
   input  logic [WIDTH-1:0] op_a,
   input  logic [WIDTH-1:0] op_b,
   input  logic             carry_in,
   output logic [WIDTH-1:0] sum
);
   if (KIND == ADDER_RIPPLE) begin : g_ripple
      logic [WIDTH-1:0] carry;
      assign carry[0] = carry_in;
      for (genvar i = 0; i < WIDTH; i++) begin : g_stage
         assign sum[i] = op_a[i] ^ op_b[i] ^ carry[i];
         if (i < WIDTH - 1) begin : g_next
            assign carry[i+1] = (op_a[i] & op_b[i]) | ((op_a[i] | op_b[i]) & carry[i]);
         end
      end
   end else begin : g_arith
      assign sum = op_a + op_b + {{(WIDTH-1){1'b0}}, carry_in};
   end

   always_comb begin
      assert_adder_sum_R3: assert (sum == WIDTH'(op_a + op_b + {{(WIDTH-1){1'b0}}, carry_in}))
         else $error("adder result disagrees with arithmetic sum");
   end
endmodule

// File: rtl/fcode_alu_select.sv
module fcode_alu_select
   import fcode_alu_pkg::*;
#(
   parameter int WIDTH = 32
) (
   input  logic [WIDTH-1:0] op_a,
   input  logic [WIDTH-1:0] b_eff,
   input  logic [WIDTH-1:0] sum,
   input  pick_e            pick,
   input  logic             invert,
   output logic [WIDTH-1:0] result
);
   always_comb begin
      unique case (pick)
         PICK_AND: result = op_a & b_eff;
         PICK_OR:  result = op_a | b_eff;
         PICK_SUM: result = sum;
         default:  result = invert ? {{(WIDTH-1){1'b0}}, sum[WIDTH-1]} : '0;
      endcase
   end

   always_comb begin
      if (pick == PICK_SIGN && !invert)
         assert_unused_zero_R4: assert (result == '0)
            else $error("unused code produced a nonzero result");
      if (pick == PICK_SIGN)
         assert_sign_upper_R7: assert (result[WIDTH-1:1] == '0)
            else $error("less-than result has upper bits set");
   end
endmodule

// File: rtl/fcode_alu.sv
module fcode_alu
   import fcode_alu_pkg::*;
#(
   parameter int WIDTH      = 32,
   parameter int ADDER_KIND = ADDER_ARITH
) (
   input  logic [WIDTH-1:0] a_in,
   input  logic [WIDTH-1:0] b_in,
   input  logic [2:0]       func,
   output logic [WIDTH-1:0] y_out,
   output logic             zero_out
);
   if (WIDTH < 2) begin : g_bad_width
      $error("fcode_alu: WIDTH must be at least 2");
   end
   if (ADDER_KIND != ADDER_ARITH && ADDER_KIND != ADDER_RIPPLE) begin : g_bad_kind
      $error("fcode_alu: unknown ADDER_KIND");
   end

   logic             invert;
   logic [WIDTH-1:0] b_eff;
   logic [WIDTH-1:0] sum;

   assign invert = func[2];

   fcode_alu_operand #(.WIDTH(WIDTH)) u_operand (
      .b_raw (b_in),
      .invert(invert),
      .b_eff (b_eff)
   );

   fcode_alu_adder #(.WIDTH(WIDTH), .KIND(ADDER_KIND)) u_adder (
      .op_a    (a_in),
      .op_b    (b_eff),
      .carry_in(invert),
      .sum     (sum)
   );

   fcode_alu_select #(.WIDTH(WIDTH)) u_select (
      .op_a  (a_in),
      .b_eff (b_eff),
      .sum   (sum),
      .pick  (pick_e'(func[1:0])),
      .invert(invert),
      .result(y_out)
   );

   assign zero_out = ~|y_out;

   always_comb begin
      if (func == 3'b000)
         assert_and_path_R1: assert (y_out == (a_in & b_in))
            else $error("AND code gave a wrong result");
      if (func == 3'b101)
         assert_orn_path_R5: assert (y_out == (a_in | ~b_in))
            else $error("OR-NOT code gave a wrong result");
      if (func == 3'b110)
         assert_sub_path_R6: assert (y_out == WIDTH'(a_in - b_in))
            else $error("subtract code gave a wrong result");
   end
endmodule

// File: tb/fcode_alu_test.sv
module fcode_alu_test;
   localparam int NW = 4;
   localparam int WW = 32;

   logic clk = 1'b0;
   logic rst = 1'b1;
   always #4 clk = ~clk;

   int errors = 0;
   int checks = 0;
   bit done   = 1'b0;

   logic [NW-1:0] a_s, b_s, y_s;
   logic [2:0]    f_s;
   logic          z_s;
   logic [WW-1:0] a_w, b_w, y_w;
   logic [2:0]    f_w;
   logic          z_w;

   fcode_alu #(.WIDTH(NW), .ADDER_KIND(1)) uut (
      .a_in(a_s), .b_in(b_s), .func(f_s), .y_out(y_s), .zero_out(z_s)
   );
   fcode_alu #(.WIDTH(WW), .ADDER_KIND(0)) uut_wide (
      .a_in(a_w), .b_in(b_w), .func(f_w), .y_out(y_w), .zero_out(z_w)
   );

   function automatic logic [63:0] model(input logic [63:0] a, input logic [63:0] b,
                                         input logic [2:0] f, input int w);
      logic [63:0] mask, d;
      mask = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
      d    = (a - b) & mask;
      case (f)
         3'd0: return a & b;
         3'd1: return a | b;
         3'd2: return (a + b) & mask;
         3'd3: return 64'd0;
         3'd4: return a & ~b & mask;
         3'd5: return (a | ~b) & mask;
         3'd6: return d;
         default: return (d >> (w - 1)) & 64'd1;
      endcase
   endfunction

   function automatic string req_of(input logic [2:0] f);
      case (f)
         3'd0: return "R1";
         3'd1: return "R2";
         3'd2: return "R3";
         3'd3: return "R4";
         3'd4, 3'd5: return "R5";
         3'd6: return "R6";
         default: return "R7";
      endcase
   endfunction

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic run_wide(input logic [WW-1:0] a, input logic [WW-1:0] b, input logic [2:0] f);
      a_w = a; b_w = b; f_w = f;
      #2;
      check(req_of(f), 64'(y_w), model(64'(a), 64'(b), f, WW));
      check("R8", 64'(z_w), 64'(model(64'(a), 64'(b), f, WW) == 64'd0));
   endtask

   initial begin
      a_s = '0; b_s = '0; f_s = '0;
      a_w = '0; b_w = '0; f_w = '0;
      repeat (2) @(posedge clk);
      rst = 1'b0;
      @(negedge clk);
      // idle state: zero operands, AND code -> zero result and zero flag (R1, R8)
      check("R1", 64'(y_w), 64'd0);
      check("R8", 64'(z_w), 64'd1);
      // exhaustive sweep on the narrow instance
      for (int f = 0; f < 8; f++) begin
         for (int a = 0; a < (1 << NW); a++) begin
            for (int b = 0; b < (1 << NW); b++) begin
               logic [63:0] e;
               a_s = NW'(a); b_s = NW'(b); f_s = 3'(f);
               #2;
               e = model(64'(a), 64'(b), 3'(f), NW);
               check(req_of(3'(f)), 64'(y_s), e);
               check("R8", 64'(z_s), 64'(e == 64'd0));
            end
         end
      end
      // wide corner cases
      run_wide(32'd25, 32'd32, 3'b111);             // R7 example -> 1
      check("R7", 64'(y_w), 64'd1);
      run_wide(32'd32, 32'd25, 3'b111);             // R7 -> 0
      run_wide(32'd7, 32'd7, 3'b111);               // R7 equal -> 0
      run_wide(32'h8000_0000, 32'd1, 3'b111);       // R7 wrap: difference MSB clear
      run_wide(32'hFFFF_FFFF, 32'd1, 3'b010);       // R3 wraps to zero, R8
      run_wide(32'd5, 32'd5, 3'b110);               // R6 zero difference
      run_wide(32'd0, 32'd1, 3'b110);               // R6 borrow
      run_wide(32'hDEAD_BEEF, 32'h1234_5678, 3'b011); // R4
      run_wide(32'hF0F0_F0F0, 32'hFF00_FF00, 3'b100); // R5
      run_wide(32'h0F0F_0000, 32'hFF00_FF00, 3'b101); // R5
      run_wide(32'hA5A5_A5A5, 32'h5A5A_5A5A, 3'b000); // R1
      run_wide(32'hA5A5_0000, 32'h5A5A_0000, 3'b001); // R2
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule